// File: doc/BRIEF.md
# Dual-Tone Keypad Tone Synthesizer

This block turns a 4-bit keypad code into the digital samples of a dual-tone signal. Each code selects one tone from a low group (697, 770, 852, 941 Hz) and one from a high group (1209, 1336, 1477, 1633 Hz). The block produces the sum of the two sine waves as one signed sample per clock cycle.

A write strobe latches the code. The code is turned into a one-hot selection for each group. Each group has its own channel. A channel divides the system clock into equal segments, and each segment steps a 5-bit phase counter through a 32-point sine table. Every tone period therefore has exactly 32 segments. Frequency is set only by the segment length, in cycles.

The high-group sample is scaled by 5/4, which is about 2 dB, before the two samples are added. The clock runs all the time. A new code changes a channel's segment length at that channel's next segment boundary and never resets its phase, so the waveform has no gap and no jump. Burst timing and conversion to analog are handled downstream.

Top module: `dtmf_tone_synth`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears. From the next edge on, `sample_o` is 0 and `row_sel_o` and `col_sel_o` are 4'b0000.
- R2: On a clock edge with `wr_en` high, `row_sel_o` and `col_sel_o` each take exactly one set bit, selected by `wr_code`. Row bit 0..3 selects 697, 770, 852, 941 Hz. Column bit 0..3 selects 1209, 1336, 1477, 1633 Hz.
- R3: The code map, written as code → (row bit, column bit), is: 1→(0,0), 2→(0,1), 3→(0,2), 4→(1,0), 5→(1,1), 6→(1,2), 7→(2,0), 8→(2,1), 9→(2,2), 11→(3,0), 10→(3,1), 12→(3,2), 13→(0,3), 14→(1,3), 15→(2,3), 0→(3,3).
- R4: A running channel's segment lasts L = round(CLK_HZ / (32·f)) clock cycles. At the end of each segment, the phase k advances by one, modulo 32. With the default CLK_HZ of 3579545, the 697 Hz tone gives L = 160.
- R5: After a write, each channel keeps its current segment length until that segment ends. The new length applies from the following segment. The phase is not reset.
- R6: At every edge, `sample_o` takes the value s(k_row) + floor(5·s(k_col)/4), where the phases are those held before the edge and s(k) = round(127·sin(2πk/32)).
- R7: After reset, both channels stay idle with phase 0, and `sample_o` stays 0. A channel starts counting its first segment at the edge after its selection first becomes non-zero.
- R8: An edge with `wr_en` low leaves both selections unchanged, whatever `wr_code` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Latch `wr_code` at this edge |
| wr_code | input | 4 | Keypad code |
| row_sel_o | output | 4 | One-hot low-group selection |
| col_sel_o | output | 4 | One-hot high-group selection |
| sample_o | output | 10 | Signed sum of the two tone samples |

## Verification
The bench builds the block with CLK_HZ = 894886, a quarter of the default. This gives segment lengths from 17 to 40 cycles, so a full 32-segment period of even the lowest tone takes only 1280 cycles. That makes it affordable to hold all sixteen codes for more than one full period and still watch code changes land in the middle of a segment. A behavioural model computes the segment lengths with real arithmetic and the sine values with `$sin`, and the bench compares the sample and both selections against this model on every clock. The run also includes back-to-back writes, a reset in the middle of a tone, and a stretch where `wr_code` changes while `wr_en` stays low.

// File: rtl/dtmf_synth_pkg.sv
// Package: dtmf_synth_pkg
// Shared constants and constant functions for the dual-tone synthesizer.
// Assumes 32 segments per tone period and an 8-bit signed sine table.
package dtmf_synth_pkg;

    localparam int PHASE_W  = 5;
    localparam int SEGS     = 1 << PHASE_W;
    localparam int SAMPLE_W = 8;
    localparam int GROUP_N  = 4;
    localparam int CODE_W   = 4;
    localparam int OUT_W    = SAMPLE_W + 2;

    typedef logic [GROUP_N-1:0] grp_sel_t;

    // Tone frequency in Hz; grp 0 = low group, grp 1 = high group.
    function automatic int tone_hz(input int grp, input int idx);
        int hz;
        if (grp == 0) begin
            case (idx)
                0:       hz = 697;
                1:       hz = 770;
                2:       hz = 852;
                default: hz = 941;
            endcase
        end else begin
            case (idx)
                0:       hz = 1209;
                1:       hz = 1336;
                2:       hz = 1477;
                default: hz = 1633;
            endcase
        end
        return hz;
    endfunction

    // Segment length in clock cycles, rounded to nearest.
    function automatic int seg_len(input int clk_hz, input int grp, input int idx);
        int f;
        f = tone_hz(grp, idx);
        return (clk_hz + (SEGS / 2) * f) / (SEGS * f);
    endfunction

    // Low-group index carried by a keypad code.
    function automatic logic [1:0] key_row(input logic [CODE_W-1:0] code);
        logic [1:0] r;
        case (code)
            4'd1, 4'd2, 4'd3, 4'd13:  r = 2'd0;
            4'd4, 4'd5, 4'd6, 4'd14:  r = 2'd1;
            4'd7, 4'd8, 4'd9, 4'd15:  r = 2'd2;
            default:                  r = 2'd3;
        endcase
        return r;
    endfunction

    // High-group index carried by a keypad code.
    function automatic logic [1:0] key_col(input logic [CODE_W-1:0] code);
        logic [1:0] c;
        case (code)
            4'd1, 4'd4, 4'd7, 4'd11:  c = 2'd0;
            4'd2, 4'd5, 4'd8, 4'd10:  c = 2'd1;
            4'd3, 4'd6, 4'd9, 4'd12:  c = 2'd2;
            default:                  c = 2'd3;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dtmf_key_decode.sv
// Module: dtmf_key_decode
// Latches a keypad code on a write strobe and holds it as two one-hot
// group selections. Assumes the code is valid in the cycle of wr_en.
module dtmf_key_decode
    import dtmf_synth_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    output grp_sel_t          row_sel_o,
    output grp_sel_t          col_sel_o
);

    grp_sel_t row_sel_q;
    grp_sel_t col_sel_q;

    // Capture the two one-hot selections when a code is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_sel_q <= '0;
            col_sel_q <= '0;
        end else if (wr_en) begin
            row_sel_q <= grp_sel_t'(1) << key_row(wr_code);
            col_sel_q <= grp_sel_t'(1) << key_col(wr_code);
        end
    end

    assign row_sel_o = row_sel_q;
    assign col_sel_o = col_sel_q;

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($countones(row_sel_q) == 1) && ($countones(col_sel_q) == 1));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(row_sel_q) && $stable(col_sel_q));

endmodule

// File: rtl/dtmf_sine_rom.sv
// Module: dtmf_sine_rom
// 32-point signed sine lookup, built from a 9-entry quarter wave by
// mirroring and sign folding. Purely combinational.
module dtmf_sine_rom
    import dtmf_synth_pkg::*;
(
    input  logic        [PHASE_W-1:0]  phase_i,
    output logic signed [SAMPLE_W-1:0] wave_o
);

    localparam int QTR = SEGS / 4;

    logic [PHASE_W-2:0]  half_idx;
    logic [PHASE_W-2:0]  qtr_idx;
    logic [SAMPLE_W-1:0] mag;

    // Fold the half-period index onto the rising quarter.
    always_comb begin
        half_idx = phase_i[PHASE_W-2:0];
        if (int'(half_idx) <= QTR) qtr_idx = half_idx;
        else                       qtr_idx = (PHASE_W-1)'(2 * QTR - int'(half_idx));
    end

    // Quarter-wave magnitude table, round(127*sin(2*pi*k/32)).
    always_comb begin
        case (qtr_idx)
            4'd0:    mag = 8'd0;
            4'd1:    mag = 8'd25;
            4'd2:    mag = 8'd49;
            4'd3:    mag = 8'd71;
            4'd4:    mag = 8'd90;
            4'd5:    mag = 8'd106;
            4'd6:    mag = 8'd117;
            4'd7:    mag = 8'd125;
            default: mag = 8'd127;
        endcase
    end

    // The second half of the period is negative.
    assign wave_o = phase_i[PHASE_W-1] ? -$signed(mag) : $signed(mag);

endmodule

// File: rtl/dtmf_tone_channel.sv
// Module: dtmf_tone_channel
// One tone channel: a reloading segment divider that steps a phase
// counter. The length is picked from a one-hot selection and applied only
// at a segment boundary. The channel is idle (phase 0) until the
// selection first becomes non-zero.
module dtmf_tone_channel
    import dtmf_synth_pkg::*;
#(
    parameter int CLK_HZ = 3579545,
    parameter int GRP    = 0,
    parameter int DIV_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  grp_sel_t           sel_i,
    output logic [PHASE_W-1:0] phase_o
);

    logic [DIV_W-1:0]   len_tab [GROUP_N];
    logic [DIV_W-1:0]   sel_len;
    logic [DIV_W-1:0]   len_q;
    logic [DIV_W-1:0]   cnt_q;
    logic [PHASE_W-1:0] phase_q;
    logic               seg_end;

    for (genvar i = 0; i < GROUP_N; i++) begin : g_len
        assign len_tab[i] = DIV_W'(seg_len(CLK_HZ, GRP, i));
    end

    // Segment length requested by the current one-hot selection.
    always_comb begin
        sel_len = '0;
        for (int i = 0; i < GROUP_N; i++) begin
            if (sel_i[i]) sel_len = sel_len | len_tab[i];
        end
    end

    assign seg_end = (len_q != '0) && (cnt_q == len_q - 1'b1);

    // Divider, phase stepping and boundary-only length reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (len_q == '0) begin
            if (sel_len != '0) begin
                len_q <= sel_len;
                cnt_q <= '0;
            end
        end else if (seg_end) begin
            cnt_q   <= '0;
            phase_q <= phase_q + 1'b1;
            len_q   <= sel_len;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_o = phase_q;

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0) |-> (cnt_q < len_q));

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_end |=> (phase_q == PHASE_W'($past(phase_q) + 1'b1)));

    // R5
    mid_seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((len_q != '0) && !seg_end) |=> $stable(len_q) && $stable(phase_q));

    // R7
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == '0) |-> (phase_q == '0));

endmodule

// File: rtl/dtmf_tone_synth.sv
// Module: dtmf_tone_synth (top)
// Dual-tone synthesizer: key decode, two tone channels (low and high
// group), two sine lookups and a mixer that adds the high-group sample
// scaled by 5/4 to the low-group sample. The output is registered.
// Assumes a free-running clock of CLK_HZ.
module dtmf_tone_synth
    import dtmf_synth_pkg::*;
#(
    parameter int CLK_HZ = 3579545
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [3:0]              wr_code,
    output logic [3:0]              row_sel_o,
    output logic [3:0]              col_sel_o,
    output logic signed [9:0]       sample_o
);

    localparam int DIV_W  = $clog2(seg_len(CLK_HZ, 0, 0) + 1);
    localparam int CHAN_N = 2;
    localparam int MUL_W  = SAMPLE_W + 3;

    grp_sel_t                    sel [CHAN_N];
    logic        [PHASE_W-1:0]   phase [CHAN_N];
    logic signed [SAMPLE_W-1:0]  wave [CHAN_N];
    logic signed [MUL_W-1:0]     hi_x5;
    logic signed [MUL_W-1:0]     hi_scaled;
    logic signed [OUT_W-1:0]     lo_ext;
    logic signed [OUT_W-1:0]     hi_ext;
    logic signed [OUT_W-1:0]     sample_q;

    dtmf_key_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .row_sel_o (sel[0]),
        .col_sel_o (sel[1])
    );

    for (genvar g = 0; g < CHAN_N; g++) begin : g_chan
        dtmf_tone_channel #(
            .CLK_HZ (CLK_HZ),
            .GRP    (g),
            .DIV_W  (DIV_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (sel[g]),
            .phase_o (phase[g])
        );

        dtmf_sine_rom u_rom (
            .phase_i (phase[g]),
            .wave_o  (wave[g])
        );
    end

    // High-group pre-emphasis: floor(5*s/4).
    always_comb begin
        hi_x5     = MUL_W'(wave[1]) * MUL_W'(5);
        hi_scaled = hi_x5 >>> 2;
        hi_ext    = OUT_W'(hi_scaled);
        lo_ext    = OUT_W'(wave[0]);
    end

    // Register the summed sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_q <= '0;
        else        sample_q <= lo_ext + hi_ext;
    end

    assign row_sel_o = sel[0];
    assign col_sel_o = sel[1];
    assign sample_o  = sample_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sample_q == '0) && (sel[0] == '0) && (sel[1] == '0));

    // R6
    sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q <= OUT_W'(285)) && (sample_q >= -OUT_W'(286)));

    // R7
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel[0] == '0) && (sel[1] == '0)) |=> (sample_q == '0));

endmodule

// File: tb/dtmf_tone_synth_tb.sv
// Bench for dtmf_tone_synth: a behavioural model with integer state and
// real-valued math is compared against the outputs on every clock.
module dtmf_tone_synth_tb;

    localparam int  CLK_HZ_TB = 894886;
    localparam real PI        = 3.14159265358979;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_code = 4'd0;
    logic [3:0]        row_sel;
    logic [3:0]        col_sel;
    logic signed [9:0] sample;

    int n_checks = 0;
    int n_errors = 0;
    bit cmp_on   = 1'b0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dtmf_tone_synth #(.CLK_HZ(CLK_HZ_TB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .row_sel_o (row_sel),
        .col_sel_o (col_sel),
        .sample_o  (sample)
    );

    string keypad = "123A456B789C*0#D";

    function automatic int char_code(byte c);
        case (c)
            "*":     return 11;
            "#":     return 12;
            "0":     return 10;
            "A":     return 13;
            "B":     return 14;
            "C":     return 15;
            "D":     return 0;
            default: return int'(c) - 48;
        endcase
    endfunction

    function automatic int key_pos(int code);
        for (int p = 0; p < 16; p++) begin
            if (char_code(keypad[p]) == code) return p;
        end
        return 0;
    endfunction

    function automatic int ref_len(int grp, int idx);
        real lo [4] = '{697.0, 770.0, 852.0, 941.0};
        real hi [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
        real f;
        f = (grp == 0) ? lo[idx] : hi[idx];
        return $rtoi(real'(CLK_HZ_TB) / (32.0 * f) + 0.5);
    endfunction

    function automatic int ref_sine(int k);
        real v;
        v = 127.0 * $sin(2.0 * PI * real'(k) / 32.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    endfunction

    function automatic int floor_5_4(int h);
        int v;
        v = 5 * h;
        return (v >= 0) ? v / 4 : -((-v + 3) / 4);
    endfunction

    // Reference model state
    int m_sel [2] = '{-1, -1};
    int m_len [2] = '{0, 0};
    int m_cnt [2] = '{0, 0};
    int m_ph  [2] = '{0, 0};
    int m_sample = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_sel[c] = -1; m_len[c] = 0; m_cnt[c] = 0; m_ph[c] = 0;
            end
            m_sample = 0;
        end else begin
            int nxt;
            int p;
            nxt = ref_sine(m_ph[0]) + floor_5_4(ref_sine(m_ph[1]));
            for (int c = 0; c < 2; c++) begin
                if (m_len[c] == 0) begin
                    if (m_sel[c] >= 0) begin
                        m_len[c] = ref_len(c, m_sel[c]);
                        m_cnt[c] = 0;
                    end
                end else if (m_cnt[c] == m_len[c] - 1) begin
                    m_cnt[c] = 0;
                    m_ph[c]  = (m_ph[c] + 1) % 32;
                    m_len[c] = ref_len(c, m_sel[c]);
                end else begin
                    m_cnt[c] = m_cnt[c] + 1;
                end
            end
            if (wr_en) begin
                p = key_pos(int'(wr_code));
                m_sel[0] = p / 4;
                m_sel[1] = p % 4;
            end
            m_sample = nxt;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sel_mask(int idx);
        return (idx < 0) ? 0 : (1 << idx);
    endfunction

    // Compare on every falling edge against the model.
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            check("R4/R5/R6 sample", int'(sample), m_sample);
            check("R2 row select", int'(row_sel), sel_mask(m_sel[0]));
            check("R2 col select", int'(col_sel), sel_mask(m_sel[1]));
        end
    end

    task automatic press(int code);
        int p;
        p = key_pos(code);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_code = 4'(code);
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 row bit for code", int'(row_sel), 1 << (p / 4));
        check("R3 col bit for code", int'(col_sel), 1 << (p % 4));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(10 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sample after reset", int'(sample), 0);
        check("R1 row after reset", int'(row_sel), 0);
        check("R1 col after reset", int'(col_sel), 0);
        cmp_on = 1'b1;

        // R7 idle until the first write
        repeat (40) @(negedge clk);
        check("R7 idle sample", int'(sample), 0);

        press(5);
        repeat (2900) @(negedge clk);

        // R8 code changes without the strobe are ignored
        for (int i = 0; i < 30; i++) begin
            wr_code = 4'(i);
            @(negedge clk);
        end
        check("R8 row unchanged", int'(row_sel), 4'b0010);
        check("R8 col unchanged", int'(col_sel), 4'b0010);

        // every code, each held past one full period (R3, R4, R6)
        for (int code = 0; code < 16; code++) begin
            press(code);
            repeat (1300 + 7 * code) @(negedge clk);
        end

        // back-to-back writes landing mid-segment (R5)
        @(negedge clk);
        wr_en = 1'b1; wr_code = 4'd2;
        @(negedge clk);
        wr_code = 4'd13;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5 last write wins row", int'(row_sel), 4'b0001);
        check("R5 last write wins col", int'(col_sel), 4'b1000);
        repeat (1500) @(negedge clk);

        // reset in the middle of a tone
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sample after mid-run reset", int'(sample), 0);
        check("R1 row after mid-run reset", int'(row_sel), 0);
        repeat (30) @(negedge clk);
        check("R7 idle after mid-run reset", int'(sample), 0);

        press(12);
        repeat (1400) @(negedge clk);
        finish_run();
    end

endmodule